// File: doc/BRIEF.md
# Dual-Lane Pixel Serializer with Frame Marker

This block turns two parallel sample streams into two serial lanes. Once per pixel period a strobe captures a 16-bit word from each of two channels. Each word then leaves MSB first on its own lane at 16 bits per pixel period. The two lanes move in lockstep and carry the same bit position in every cycle.

Next to the lanes the block drives a frame marker and a forwarded bit clock. The frame marker rises together with the MSB of each pixel. The point where it falls depends on the sampling mode. In sample-hold mode it falls every pixel as bit 7 begins. In correlated-double-sampling mode it falls where bit 9 begins on one pixel and where bit 7 begins on the next, alternating. The forwarded clock rises in the middle of every data bit, so a receiver can latch each lane on that edge.

The block runs on an internal clock at twice the bit rate, which is 32 clocks per pixel. At this clock rate, pixel rates from 5 MHz to 40 MHz give lane rates from 80 to 640 Mbit/s.

Top module: `dual_lane_ser`

## Requirements
- R1: While reset is held, and after reset until the first pixel strobe has been taken, `lane_a`, `lane_b`, `frame_mark` and `bit_clk` all stay low.
- R2: A pixel strobe that is seen at clock edge E, while the block is idle, starts the first pixel at edge E+1. After E+1, both lanes show bit 15 of the captured samples.
- R3: Each lane sends its sample MSB first. Every bit lasts 2 clocks, and a pixel lasts 32 clocks. Bit k of a pixel, counted from 0 at the MSB, is shown in the clocks after boundary edge +2k and +2k+1. The lanes change only at even phases.
- R4: While running, `bit_clk` is low in the first clock of each bit and high in the second clock. It therefore toggles on every clock and rises mid-bit.
- R5: `frame_mark` rises at each pixel boundary, in the same clock where bit 15 appears.
- R6: With `mode_cds`=0 (sample-hold), `frame_mark` stays high for 16 clocks (bits 15 to 8) and falls as bit 7 starts.
- R7: With `mode_cds`=1 (correlated double sampling), the first such pixel after reset keeps `frame_mark` high for 12 clocks, falling as bit 9 starts. The next such pixel keeps it high for 16 clocks, and the two lengths alternate. Only pixels in this mode advance the alternation.
- R8: `mode_cds` is sampled only at the pixel boundary edge. A change in the middle of a pixel affects only the next pixel.
- R9: `samp_a` and `samp_b` are captured only in a strobe cycle. Later changes on them without a strobe do not alter the words being sent. Each pixel sends the words captured by the most recent strobe before its boundary. The strobe must not coincide with the boundary edge, which is phase 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the lane bit rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_stb | input | 1 | One-cycle pixel strobe that captures both samples |
| samp_a | input | 16 | Sample word for lane A |
| samp_b | input | 16 | Sample word for lane B |
| mode_cds | input | 1 | 0 = sample-hold, 1 = correlated double sampling |
| lane_a | output | 1 | Serial data lane A |
| lane_b | output | 1 | Serial data lane B |
| frame_mark | output | 1 | Pixel frame marker |
| bit_clk | output | 1 | Forwarded clock that rises mid-bit |

## Verification
The first pixel boundary comes one clock after the strobe is captured. From then on, every output is a register, so the value for phase k of a pixel appears in the clock after boundary edge +k. The bench samples on the falling edge and compares each output with a value it computes for that phase. It drives the next pixel's strobe, mode and a later burst of unrelated data at phase 10. This tests that capture happens only on the strobe and that the mode is sampled only at the boundary. The frame length is also checked against a separate alternation model kept in the bench.

// File: rtl/dlser_pkg.sv
package dlser_pkg;

  typedef enum logic {SMP_HOLD = 1'b0, SMP_CDS = 1'b1} smp_mode_e;

  // number of clocks the frame marker stays high in one pixel
  function automatic int unsigned frame_high_phases(input logic cds, input logic long_sel,
                                                    input int unsigned sh_bits,
                                                    input int unsigned short_bits);
    int unsigned nb;
    nb = (cds && !long_sel) ? short_bits : sh_bits;
    return 2 * nb;
  endfunction

endpackage

// File: rtl/dlser_phase.sv
module dlser_phase #(
  parameter int unsigned W  = 16,
  localparam int unsigned NPH = 2 * W,
  localparam int unsigned PW  = $clog2(NPH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_stb,
  output logic          run,
  output logic          bnd,
  output logic [PW-1:0] ph,
  output logic          bclk
);
  localparam logic [PW-1:0] LAST = PW'(NPH - 1);

  logic have;
  logic start;

  assign start = !run && have;
  assign bnd   = start || (run && ph == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      have <= 1'b0;
      ph   <= '0;
      bclk <= 1'b0;
    end else begin
      if (pix_stb) have <= 1'b1;
      if (bnd) begin
        run  <= 1'b1;
        ph   <= '0;
        bclk <= 1'b0;
      end else if (run) begin
        ph   <= ph + 1'b1;
        bclk <= ~ph[0];
      end
    end
  end

  // R4
  bclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    run |=> (bclk != $past(bclk)));

  // R1
  idle_clk_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> !bclk);

endmodule

// File: rtl/dlser_lane.sv
module dlser_lane #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pix_stb,
  input  logic [W-1:0] din,
  input  logic         bnd,
  input  logic         shift_en,
  output logic         dout
);
  logic [W-1:0] hold;
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      sh   <= '0;
    end else begin
      if (pix_stb) hold <= din;
      if (bnd)           sh <= hold;
      else if (shift_en) sh <= {sh[W-2:0], 1'b0};
    end
  end

  assign dout = sh[W-1];

  // R9
  hold_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_stb |=> $stable(hold));

endmodule

// File: rtl/dlser_frame.sv
module dlser_frame #(
  parameter int unsigned PW         = 5,
  parameter int unsigned SH_BITS    = 8,
  parameter int unsigned SHORT_BITS = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          bnd,
  input  logic [PW-1:0] ph,
  input  logic          mode_cds,
  output logic          frm
);
  import dlser_pkg::*;

  localparam logic [PW-1:0] PH_SH    = PW'(2 * SH_BITS);
  localparam logic [PW-1:0] PH_SHORT = PW'(2 * SHORT_BITS);

  logic      cur_cds;
  logic      cur_long;
  logic      alt;
  logic [PW:0] nxt_ph;
  logic [PW:0] hi_len;

  assign nxt_ph = {1'b0, ph} + 1'b1;
  assign hi_len = (PW+1)'(frame_high_phases(cur_cds, cur_long, SH_BITS, SHORT_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_cds  <= 1'b0;
      cur_long <= 1'b1;
      alt      <= 1'b0;
      frm      <= 1'b0;
    end else if (bnd) begin
      cur_cds <= mode_cds;
      frm     <= 1'b1;
      if (mode_cds == SMP_CDS) begin
        cur_long <= alt;
        alt      <= ~alt;
      end else begin
        cur_long <= 1'b1;
      end
    end else if (run) begin
      frm <= (nxt_ph < hi_len);
    end
  end

  // R5
  frame_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frm) |-> (run && ph == '0));

  // R6
  frame_fall_pos_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(frm) |-> (ph == PH_SH || ph == PH_SHORT));

  // R7
  cds_alternate_chk: assert property (@(posedge clk) disable iff (rst)
    (bnd && mode_cds) |=> (alt != $past(alt)));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bnd |=> $stable(cur_cds));

endmodule

// File: rtl/dual_lane_ser.sv
module dual_lane_ser #(
  parameter int unsigned W          = 16,
  parameter int unsigned SH_BITS    = 8,
  parameter int unsigned SHORT_BITS = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pix_stb,
  input  logic [W-1:0] samp_a,
  input  logic [W-1:0] samp_b,
  input  logic         mode_cds,
  output logic         lane_a,
  output logic         lane_b,
  output logic         frame_mark,
  output logic         bit_clk
);
  localparam int unsigned NLANE = 2;
  localparam int unsigned PW    = $clog2(2 * W);

  logic          run;
  logic          bnd;
  logic [PW-1:0] ph;
  logic          shift_en;
  logic [W-1:0]  din  [NLANE];
  logic          dout [NLANE];

  assign din[0] = samp_a;
  assign din[1] = samp_b;

  dlser_phase #(.W(W)) u_phase (
    .clk(clk), .rst(rst), .pix_stb(pix_stb),
    .run(run), .bnd(bnd), .ph(ph), .bclk(bit_clk)
  );

  // shift when the next phase is even, i.e. a new bit begins
  assign shift_en = run && !bnd && ph[0];

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    dlser_lane #(.W(W)) u_lane (
      .clk(clk), .rst(rst), .pix_stb(pix_stb), .din(din[i]),
      .bnd(bnd), .shift_en(shift_en), .dout(dout[i])
    );
  end

  assign lane_a = dout[0];
  assign lane_b = dout[1];

  dlser_frame #(.PW(PW), .SH_BITS(SH_BITS), .SHORT_BITS(SHORT_BITS)) u_frame (
    .clk(clk), .rst(rst), .run(run), .bnd(bnd), .ph(ph),
    .mode_cds(mode_cds), .frm(frame_mark)
  );

  // R3
  lane_even_change_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !bnd && !ph[0]) |=> ($stable(lane_a) && $stable(lane_b)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> (!lane_a && !lane_b && !frame_mark));

endmodule

// File: tb/dual_lane_ser_test.sv
module dual_lane_ser_test;
  localparam int NP = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_stb = 1'b0;
  logic [15:0] samp_a = '0, samp_b = '0;
  logic mode_cds = 1'b0;
  logic lane_a, lane_b, frame_mark, bit_clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] da [NP+1];
  logic [15:0] db [NP+1];
  logic        md [NP+1];

  always #2.5 clk = ~clk;

  dual_lane_ser uut (
    .clk(clk), .rst(rst), .pix_stb(pix_stb), .samp_a(samp_a), .samp_b(samp_b),
    .mode_cds(mode_cds), .lane_a(lane_a), .lane_b(lane_b),
    .frame_mark(frame_mark), .bit_clk(bit_clk)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // clocks the marker stays high: 8 bits, or 6 bits on the first of each CDS pair
  function automatic int high_clocks(input bit cds, input bit second);
    if (cds && !second) return 12;
    return 16;
  endfunction

  function automatic bit lane_bit(input logic [15:0] w, input int k);
    return w[15 - k / 2];
  endfunction

  initial begin
    #(20000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit pair_second;
    int hl;
    void'($urandom(32'd4242));
    for (int p = 0; p <= NP; p++) begin
      da[p] = 16'($urandom);
      db[p] = 16'($urandom);
      md[p] = 1'($urandom);
    end
    da[0] = 16'h8000; db[0] = 16'h0001;
    da[1] = 16'hFFFF; db[1] = 16'h0000;
    da[2] = 16'hAAAA; db[2] = 16'h5555;
    md[0] = 1; md[1] = 1; md[2] = 0; md[3] = 1; md[4] = 1; md[5] = 0;

    // R1: reset state
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!lane_a && !lane_b && !frame_mark && !bit_clk, "R1 reset",
          {lane_a, lane_b, frame_mark, bit_clk}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!lane_a && !lane_b && !frame_mark && !bit_clk, "R1 idle before strobe",
          {lane_a, lane_b, frame_mark, bit_clk}, 0);

    pix_stb = 1'b1; samp_a = da[0]; samp_b = db[0]; mode_cds = md[0];
    @(negedge clk);
    pix_stb = 1'b0; samp_a = 16'h1234; samp_b = 16'hFEDC;
    check(!lane_a && !lane_b && !frame_mark, "R2 not started at capture edge",
          {lane_a, lane_b, frame_mark}, 0);

    pair_second = 0;
    for (int p = 0; p < NP; p++) begin
      if (md[p]) begin
        hl = high_clocks(1, pair_second);
        pair_second = !pair_second;
      end else begin
        hl = high_clocks(0, 0);
      end
      for (int k = 0; k < 32; k++) begin
        @(negedge clk);
        check(lane_a == lane_bit(da[p], k), (p == 0 && k == 0) ? "R2 lane_a MSB" : "R3/R9 lane_a",
              lane_a, lane_bit(da[p], k));
        check(lane_b == lane_bit(db[p], k), "R3/R9 lane_b", lane_b, lane_bit(db[p], k));
        check(bit_clk == k[0], "R4 bit_clk", bit_clk, k[0]);
        if (k == 0)
          check(frame_mark == 1'b1, "R5 frame rise", frame_mark, 1);
        else if (p > 0 && md[p] != md[p-1])
          check(frame_mark == (k < hl), "R8 mode switch", frame_mark, (k < hl));
        else
          check(frame_mark == (k < hl), md[p] ? "R7 cds frame" : "R6 sh frame",
                frame_mark, (k < hl));
        if (k == 10) begin
          pix_stb = 1'b1; samp_a = da[p+1]; samp_b = db[p+1]; mode_cds = md[p+1];
        end else if (k == 11) begin
          pix_stb = 1'b0; samp_a = ~da[p+1]; samp_b = 16'($urandom);
        end
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule